// File: doc/BRIEF.md
# Nine-bit multiprocessor serial receiver with address filtering

This block receives asynchronous serial frames on a multidrop network in which each frame carries a ninth bit after the eight data bits. That ninth bit marks the byte as either a node address (1) or data (0). The receiver oversamples the line at sixteen times the bit rate. It checks each start bit at its middle and samples every later bit at its centre. It then checks one or two stop bits.

Every completed frame updates the received byte and its flags. A filter decides whether the frame also raises a one-cycle receive interrupt. The filter uses the enable bit, a two-bit mode, the programmed node address and an internal "selected" latch, so software is only disturbed by traffic meant for it. A read-only status word shows the address flag, the framing error, the selected latch and whether a frame is in progress.

A frame is a start bit (0), data bits 0..7 sent LSB first, the address/data bit, then one stop bit (1), or two stop bits when `two_stop_i` is set. The idle line is 1.

Top module: `mp_uart_rx`

## Requirements
- R1: On every completed frame, `data_o` takes data bits 0..7 (first received bit in `data_o[0]`) and `addr_flag_o` takes the ninth bit; these and `ferr_o` are held unchanged until the next frame completes.
- R2: A low level on the line that has ended before the middle of the start bit (fewer than 8 oversampling ticks) is discarded: no output, flag or interrupt changes.
- R3: A stop bit sampled as 0 sets `ferr_o` to 1 for that byte and no interrupt is raised; with `two_stop_i` = 1 the second stop bit is checked as well.
- R4: With `en_i` = 0, every correctly framed byte interrupts, whatever its ninth bit.
- R5: With `en_i` = 1 and `mode_i` = 2'b00, every correctly framed byte interrupts.
- R6: With `en_i` = 1 and `mode_i` = 2'b01, every correctly framed address byte interrupts, whatever its value, and data bytes never interrupt.
- R7: With `en_i` = 1 and `mode_i` = 2'b10, an address byte interrupts only if it equals `node_addr_i`, and a data byte interrupts only while the node is selected.
- R8: With `en_i` = 1 and `mode_i` = 2'b11, address bytes never interrupt, and a data byte interrupts only while the node is selected.
- R9: In any mode, a correctly framed address byte sets the selected latch when it equals `node_addr_i` and clears it otherwise. Data bytes and bytes with a framing error leave it unchanged. It is visible as `stat_o[2]` and is 0 after reset.
- R10: `irq_o` is a single-cycle pulse, asserted in the same cycle that `data_o` shows the byte that caused it.
- R11: After reset, `data_o`, `addr_flag_o`, `ferr_o`, `irq_o` and `stat_o` are all 0. `stat_o` bits: [0] address flag, [1] framing error, [2] selected, [3] frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Oversampling tick, 16 per bit time |
| en_i | input | 1 | Multiprocessor filtering enable |
| mode_i | input | 2 | Filtering mode |
| node_addr_i | input | 8 | Node address to match |
| two_stop_i | input | 1 | Expect two stop bits |
| data_o | output | 8 | Last received byte |
| addr_flag_o | output | 1 | Last byte was an address byte |
| ferr_o | output | 1 | Last byte had a framing error |
| irq_o | output | 1 | Receive interrupt pulse |
| stat_o | output | 4 | Status view: {busy, selected, ferr, addr_flag} |

## Verification
If the selected latch holds the wrong value, the error only shows at the ports on the next data byte, in the matched or data-only mode. That byte interrupts when it should not, or stays silent when it should interrupt. The same wrong value shows at once in `stat_o[2]`, which is compared after every frame. An error in the bit counter or the sampling phase shifts or corrupts `data_o` at the end of the very next frame. A start check that fires too early turns a short glitch into a spurious byte. The hold on the outputs is compared on every clock between frames.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;
  typedef enum logic [1:0] {
    MD_ALL      = 2'b00,
    MD_ADDR     = 2'b01,
    MD_MATCH    = 2'b10,
    MD_SEL_DATA = 2'b11
  } mp_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_STOP1,
    S_STOP2,
    S_WAITHI
  } rx_state_e;
endpackage

// File: rtl/mp_rx_sync.sv
module mp_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/mp_rx_deser.sv
module mp_rx_deser
  import mp_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tick_i,
  input  logic          two_stop_i,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          nine_o,
  output logic          ferr_o,
  output logic          busy_o
);
  localparam int NB = DW + 1;
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(NB);
  localparam logic [CW-1:0] CNT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OSR / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NB - 1);

  rx_state_e       st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bidx;
  logic [NB-1:0]   shreg;
  logic            done_q, ferr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      shreg  <= '0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          if (!rx_i) st <= S_START;
        end
        S_START: if (tick_i) begin
          if (cnt == CNT_MID) begin
            cnt  <= '0;
            bidx <= '0;
            st   <= rx_i ? S_IDLE : S_DATA;  // false start when high at mid-bit
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: if (tick_i) begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            shreg <= {rx_i, shreg[NB-1:1]};
            if (bidx == BIT_LAST) st <= S_STOP1;
            else                  bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP1: if (tick_i) begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (!rx_i) begin
              done_q <= 1'b1;
              ferr_q <= 1'b1;
              st     <= S_WAITHI;
            end else if (two_stop_i) begin
              st <= S_STOP2;
            end else begin
              done_q <= 1'b1;
              ferr_q <= 1'b0;
              st     <= S_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_STOP2: if (tick_i) begin
          if (cnt == CNT_LAST) begin
            cnt    <= '0;
            done_q <= 1'b1;
            ferr_q <= ~rx_i;
            st     <= rx_i ? S_IDLE : S_WAITHI;
          end else cnt <= cnt + 1'b1;
        end
        S_WAITHI: if (rx_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign byte_o = shreg[DW-1:0];
  assign nine_o = shreg[NB-1];
  assign ferr_o = ferr_q;
  assign busy_o = (st != S_IDLE);
endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
  import mp_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] byte_i,
  input  logic          nine_i,
  input  logic          ferr_i,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] node_addr_i,
  output logic          pass_o,
  output logic          sel_o
);
  logic     sel_q, sel_d, addr_hit, good;
  mp_mode_e mode;

  assign mode     = mp_mode_e'(mode_i);
  assign addr_hit = (byte_i == node_addr_i);
  assign good     = done_i && !ferr_i;

  always_comb begin
    pass_o = 1'b0;
    sel_d  = sel_q;
    if (good) begin
      if (nine_i) sel_d = addr_hit;
      if (!en_i) pass_o = 1'b1;
      else begin
        unique case (mode)
          MD_ALL:      pass_o = 1'b1;
          MD_ADDR:     pass_o = nine_i;
          MD_MATCH:    pass_o = nine_i ? addr_hit : sel_q;
          MD_SEL_DATA: pass_o = !nine_i && sel_q;
          default:     pass_o = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel_d;

  assign sel_o = sel_q;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mp_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rxd_i,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] node_addr_i,
  input  logic          two_stop_i,
  output logic [DW-1:0] data_o,
  output logic          addr_flag_o,
  output logic          ferr_o,
  output logic          irq_o,
  output logic [3:0]    stat_o
);
  logic          rx_s;
  logic          frm_done, frm_nine, frm_ferr, busy;
  logic [DW-1:0] frm_byte;
  logic          pass, sel;

  mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  mp_rx_deser #(.OSR(OSR), .DW(DW)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (rx_s),
    .tick_i    (tick_i),
    .two_stop_i(two_stop_i),
    .done_o    (frm_done),
    .byte_o    (frm_byte),
    .nine_o    (frm_nine),
    .ferr_o    (frm_ferr),
    .busy_o    (busy)
  );

  mp_rx_filter #(.DW(DW)) u_filter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (frm_done),
    .byte_i     (frm_byte),
    .nine_i     (frm_nine),
    .ferr_i     (frm_ferr),
    .en_i       (en_i),
    .mode_i     (mode_i),
    .node_addr_i(node_addr_i),
    .pass_o     (pass),
    .sel_o      (sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o      <= '0;
      addr_flag_o <= 1'b0;
      ferr_o      <= 1'b0;
      irq_o       <= 1'b0;
    end else begin
      irq_o <= pass;
      if (frm_done) begin
        data_o      <= frm_byte;
        addr_flag_o <= frm_nine;
        ferr_o      <= frm_ferr;
      end
    end
  end

  assign stat_o = {busy, sel, ferr_o, addr_flag_o};
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] node_addr_i,
  input logic          frm_done,
  input logic [DW-1:0] data_o,
  input logic          addr_flag_o,
  input logic          ferr_o,
  input logic          irq_o,
  input logic [3:0]    stat_o
);
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frm_done) |-> ($stable(data_o) && $stable(addr_flag_o) && $stable(ferr_o)));

  p_no_irq_on_ferr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !ferr_o);

  p_addr_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(en_i) && $past(mode_i) == 2'b01) |-> addr_flag_o);

  p_match_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && addr_flag_o && $past(en_i) && $past(mode_i) == 2'b10) |-> data_o == $past(node_addr_i));

  p_data_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && $past(en_i) && $past(mode_i) == 2'b11) |-> (!addr_flag_o && stat_o[2]));

  p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_with_update_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(frm_done));
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .mode_i     (mode_i),
  .node_addr_i(node_addr_i),
  .frm_done   (frm_done),
  .data_o     (data_o),
  .addr_flag_o(addr_flag_o),
  .ferr_o     (ferr_o),
  .irq_o      (irq_o),
  .stat_o     (stat_o)
);

// File: tb/mp_uart_rx_tb.sv
`timescale 1ns/1ps
module mp_uart_rx_tb;
  localparam int TICK_DIV = 4;
  localparam int BIT_CLK  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick;
  logic       en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [7:0] node = 8'h5A;
  logic       two_stop = 1'b0;
  logic [7:0] data_o;
  logic       addr_flag_o, ferr_o, irq_o;
  logic [3:0] stat_o;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  logic [7:0] irq_data = '0;
  logic irq_prev = 1'b0;
  logic hold_chk = 1'b0;
  logic [7:0] exp_data = '0;
  logic exp_addr = 1'b0, exp_ferr = 1'b0;
  logic m_sel = 1'b0;
  int tdiv = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) tdiv <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  assign tick = (tdiv == 0);

  mp_uart_rx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick_i(tick),
    .en_i(en), .mode_i(mode), .node_addr_i(node), .two_stop_i(two_stop),
    .data_o(data_o), .addr_flag_o(addr_flag_o), .ferr_o(ferr_o),
    .irq_o(irq_o), .stat_o(stat_o)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_o) begin
        irq_cnt++;
        irq_data = data_o;
        chk(!irq_prev, "R10 pulse width", 2, 1);
      end
      irq_prev = irq_o;
      if (hold_chk) begin
        chk(data_o == exp_data && addr_flag_o == exp_addr && ferr_o == exp_ferr,
            "R1/R2 hold", {data_o, addr_flag_o, ferr_o}, {exp_data, exp_addr, exp_ferr});
        chk(!irq_o, "R2 no irq while idle", irq_o, 0);
      end
    end
  end

  task automatic put(input logic b);
    rxd = b;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  function automatic int model_irq(input logic [8:0] w, input logic fe);
    if (fe) return 0;
    if (!en) return 1;
    case (mode)
      2'b00:   return 1;
      2'b01:   return w[8] ? 1 : 0;
      2'b10:   return w[8] ? ((w[7:0] == node) ? 1 : 0) : (m_sel ? 1 : 0);
      default: return (!w[8] && m_sel) ? 1 : 0;
    endcase
  endfunction

  task automatic frame(input logic [8:0] w, input logic s1, input logic s2, input string req);
    logic fe;
    int exp_irq, base;
    fe = !s1 || (two_stop && !s2);
    exp_irq = model_irq(w, fe);
    if (!fe && w[8]) m_sel = (w[7:0] == node);
    hold_chk = 1'b0;
    base = irq_cnt;
    put(1'b0);
    for (int i = 0; i < 9; i++) put(w[i]);
    put(s1);
    if (two_stop) put(s2);
    rxd = 1'b1;
    repeat (96) @(negedge clk);
    chk(irq_cnt - base == exp_irq, req, irq_cnt - base, exp_irq);
    chk(data_o == w[7:0], "R1 data", data_o, w[7:0]);
    chk(addr_flag_o == w[8], "R1 addr flag", addr_flag_o, w[8]);
    chk(ferr_o == fe, "R3 ferr", ferr_o, fe);
    chk(stat_o[2] == m_sel, "R9 selected", stat_o[2], m_sel);
    chk(stat_o[1:0] == {fe, w[8]}, "R11 stat bits", stat_o[1:0], {fe, w[8]});
    if (exp_irq != 0) chk(irq_data == w[7:0], "R10 data at irq", irq_data, w[7:0]);
    exp_data = w[7:0];
    exp_addr = w[8];
    exp_ferr = fe;
    hold_chk = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(data_o == 0 && addr_flag_o == 0 && ferr_o == 0 && irq_o == 0 && stat_o == 0,
        "R11 reset", {data_o, addr_flag_o, ferr_o, irq_o, stat_o}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    hold_chk = 1'b1;

    en = 1'b0;
    frame({1'b0, 8'h3C}, 1, 1, "R4 data");
    frame({1'b1, 8'h11}, 1, 1, "R4 addr");

    en = 1'b1; mode = 2'b00;
    frame({1'b1, 8'hA5}, 1, 1, "R5 addr");
    frame({1'b0, 8'h00}, 1, 1, "R5 data");

    mode = 2'b01;
    frame({1'b1, 8'h77}, 1, 1, "R6 any addr");
    frame({1'b0, 8'hFF}, 1, 1, "R6 data silent");
    frame({1'b1, 8'h5A}, 1, 1, "R6 own addr");

    mode = 2'b10;
    frame({1'b0, 8'h12}, 1, 1, "R7 data selected");
    frame({1'b1, 8'h33}, 1, 1, "R7 foreign addr");
    frame({1'b0, 8'h44}, 1, 1, "R7 data deselected");
    frame({1'b1, 8'h5A}, 1, 1, "R7 match addr");
    frame({1'b0, 8'h81}, 1, 1, "R7 data reselected");

    mode = 2'b11;
    frame({1'b1, 8'h5A}, 1, 1, "R8 match addr silent");
    frame({1'b0, 8'h9C}, 1, 1, "R8 data selected");
    frame({1'b1, 8'h01}, 1, 1, "R8 foreign addr");
    frame({1'b0, 8'h9D}, 1, 1, "R8 data deselected");

    frame({1'b1, 8'h5A}, 0, 1, "R9 errored addr keeps latch");
    frame({1'b0, 8'h9E}, 1, 1, "R9 still deselected");
    mode = 2'b00;
    frame({1'b0, 8'h55}, 0, 1, "R3 bad stop");

    two_stop = 1'b1;
    frame({1'b0, 8'h66}, 1, 1, "R3 two stops ok");
    frame({1'b0, 8'h67}, 1, 0, "R3 bad second stop");
    frame({1'b1, 8'hC3}, 0, 1, "R3 bad first of two");
    two_stop = 1'b0;

    // short glitch, checked every clock by the hold comparison (R2)
    begin
      int base;
      base = irq_cnt;
      rxd = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk);
      rxd = 1'b1;
      repeat (2 * BIT_CLK) @(negedge clk);
      chk(irq_cnt == base, "R2 glitch irq", irq_cnt - base, 0);
      chk(stat_o[3] == 1'b0, "R2 back to idle", stat_o[3], 0);
    end
    frame({1'b0, 8'hB7}, 1, 1, "R5 after glitch");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule